// File: doc/BRIEF.md
# Device feature chain enumerator

This block is a small bus master that discovers the features present in a memory-mapped region. Each feature carries a self-describing 64-bit header. The first header word holds a type, a layout version, an end-of-chain flag, a byte offset to the next header, a revision and an identifier. It is followed by a 128-bit GUID. Headers whose layout version is 1 also carry two more words: one says where the feature's registers sit, and one gives the size of that register set along with grouping information.

After a start pulse, the engine reads the header at the given base address one 64-bit word at a time. It uses a request/response port that has variable latency. When the header is complete, it presents one feature record on a valid/ready output. It then jumps to the next header by adding the header's next offset to the header's own address. This repeats until a header flags the end of the chain. A header with a zero offset and no end flag also ends the walk, as a chain error, so a damaged list cannot make the walk loop forever. A one-cycle done pulse reports how many records were delivered.

Top module: `feature_walker`

## Requirements
- R1: The record decodes header word 0 as follows: type is bits 63:60, layout version is 59:52, end-of-chain is bit 40, next offset is 39:16, revision is 15:12 and identifier is 11:0. Bits 51:41 are ignored.
- R2: Reads are 64-bit and word aligned, and only one read is outstanding at a time. A request holds its address until it is accepted. A header of version 1 costs five reads, at byte offsets 0x00, 0x08, 0x10, 0x18 and 0x20. A header of any other version costs three reads, at 0x00, 0x08 and 0x10.
- R3: The record GUID is the word at offset 0x10 (upper half) joined to the word at offset 0x08 (lower half).
- R4: The first header is at the start address. Each following header is at the previous header address plus the previous next offset.
- R5: For a version-1 header, take the word at offset 0x18. If its bit 0 is 1, the register base is that word with bit 0 cleared. If its bit 0 is 0, the register base is the header address plus that word.
- R6: For a version-1 header, the word at offset 0x20 gives the register size (63:32), the has-parameters flag (31), the group (30:16) and the instance (15:0). For any other version, the register base is the header address, the register size is the next offset, and the flag, group and instance are zero.
- R7: The record span always equals the next offset. When the end-of-chain bit is set, the record is marked last and the walk ends after that record.
- R8: A header with a zero next offset and the end-of-chain bit clear gives a record marked both error and last. The walk then ends, with the done error flag set.
- R9: A presented record keeps every field stable until it is accepted.
- R10: One cycle after the last record is accepted, done pulses for exactly one cycle. The done count equals the number of records accepted in the walk.
- R11: A start pulse during a walk has no effect on the headers visited or on the record count.
- R12: Synchronous reset returns the engine to idle, with no request, no record and no done, even in the middle of a walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (used only when idle) |
| base_addr | input | AW | Byte address of the first header |
| req_valid | output | 1 | Read request pending |
| req_ready | input | 1 | Read request accepted |
| req_addr | output | AW | Byte address of the read |
| resp_valid | input | 1 | Read data returned |
| resp_data | input | 64 | Read data |
| rec_valid | output | 1 | Feature record present |
| rec_ready | input | 1 | Consumer takes the record |
| rec_hdr_addr | output | AW | Header address of this feature |
| rec_type | output | 4 | Feature type |
| rec_dfh_ver | output | 8 | Header layout version |
| rec_rev | output | 4 | Feature revision |
| rec_id | output | 12 | Feature identifier |
| rec_guid | output | 128 | Feature GUID |
| rec_span | output | 24 | Next offset, or size of the last feature |
| rec_reg_base | output | AW | Register set base address |
| rec_reg_size | output | 32 | Register set size |
| rec_has_params | output | 1 | Parameter blocks present |
| rec_group | output | 15 | Group identifier |
| rec_inst | output | 16 | Instance identifier |
| rec_last | output | 1 | Final record of the walk |
| rec_err | output | 1 | Chain error at this header |
| done | output | 1 | Walk finished (one cycle) |
| done_count | output | CW | Records delivered in the walk |
| done_err | output | 1 | Walk ended on a chain error |

## Verification
The checker assumes that the memory side returns exactly one response for each accepted request, and never sends a response without a request. It also assumes that the consumer drives rec_ready as a plain level. The bench's responder meets these assumptions. It raises ready only when a request is pending and accepts one request at a time. It returns each word after a random delay of zero to three cycles, and drops any pending reply when reset is asserted. Chains are laid out so that the headers never overlap and every next offset is word aligned.

// File: rtl/fw_pkg.sv
package fw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ, ST_WAIT, ST_EMIT, ST_DONE
  } walk_st_e;

  typedef struct packed {
    logic [3:0]  kind;
    logic [7:0]  hver;
    logic [10:0] rsvd;
    logic        eol;
    logic [23:0] nxt;
    logic [3:0]  rev;
    logic [11:0] fid;
  } hdr_t;

  localparam int          WORD_BYTES  = 8;
  localparam int          BASIC_WORDS = 3;
  localparam int          EXT_WORDS   = 5;
  localparam logic [7:0]  EXT_VER     = 8'd1;
endpackage

// File: rtl/fw_hdr_fields.sv
module fw_hdr_fields
  import fw_pkg::*;
(
  input  logic [63:0] word0,
  output hdr_t        fld,
  output logic        is_ext,
  output logic        chain_err,
  output logic        is_last
);
  always_comb begin
    fld       = hdr_t'(word0);
    is_ext    = (fld.hver == EXT_VER);
    chain_err = !fld.eol && (fld.nxt == 24'd0);
    is_last   = fld.eol || chain_err;
  end
endmodule

// File: rtl/fw_place.sv
module fw_place #(
  parameter int AW = 64
) (
  input  logic [AW-1:0] hdr_addr,
  input  logic          is_ext,
  input  logic [23:0]   nxt,
  input  logic [63:0]   loc_word,
  input  logic [63:0]   size_word,
  output logic [AW-1:0] reg_base,
  output logic [31:0]   reg_size,
  output logic          has_params,
  output logic [14:0]   group_id,
  output logic [15:0]   inst_id
);
  logic [AW-1:0] loc_a;
  assign loc_a = loc_word[AW-1:0];

  always_comb begin
    if (!is_ext) begin
      reg_base   = hdr_addr;
      reg_size   = {8'd0, nxt};
      has_params = 1'b0;
      group_id   = '0;
      inst_id    = '0;
    end else begin
      reg_base   = loc_a[0] ? {loc_a[AW-1:1], 1'b0} : hdr_addr + loc_a;
      reg_size   = size_word[63:32];
      has_params = size_word[31];
      group_id   = size_word[30:16];
      inst_id    = size_word[15:0];
    end
  end
endmodule

// File: rtl/feature_walker.sv
module feature_walker
  import fw_pkg::*;
#(
  parameter int AW = 64,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] base_addr,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_addr,
  input  logic          resp_valid,
  input  logic [63:0]   resp_data,
  output logic          rec_valid,
  input  logic          rec_ready,
  output logic [AW-1:0] rec_hdr_addr,
  output logic [3:0]    rec_type,
  output logic [7:0]    rec_dfh_ver,
  output logic [3:0]    rec_rev,
  output logic [11:0]   rec_id,
  output logic [127:0]  rec_guid,
  output logic [23:0]   rec_span,
  output logic [AW-1:0] rec_reg_base,
  output logic [31:0]   rec_reg_size,
  output logic          rec_has_params,
  output logic [14:0]   rec_group,
  output logic [15:0]   rec_inst,
  output logic          rec_last,
  output logic          rec_err,
  output logic          done,
  output logic [CW-1:0] done_count,
  output logic          done_err
);
  localparam int IW = $clog2(EXT_WORDS);
  localparam int SH = $clog2(WORD_BYTES);

  walk_st_e      state;
  logic [AW-1:0] hdr_addr;
  logic [IW-1:0] widx;
  logic [63:0]   wrd [EXT_WORDS];
  logic [CW-1:0] count;
  logic          err_r;

  hdr_t fld;
  logic is_ext, chain_err, is_last, last_word;

  fw_hdr_fields u_fields (
    .word0(wrd[0]), .fld(fld), .is_ext(is_ext),
    .chain_err(chain_err), .is_last(is_last)
  );

  fw_place #(.AW(AW)) u_place (
    .hdr_addr(hdr_addr), .is_ext(is_ext), .nxt(fld.nxt),
    .loc_word(wrd[3]), .size_word(wrd[4]),
    .reg_base(rec_reg_base), .reg_size(rec_reg_size),
    .has_params(rec_has_params), .group_id(rec_group), .inst_id(rec_inst)
  );

  assign last_word = (widx == IW'(EXT_WORDS - 1)) ||
                     ((widx == IW'(BASIC_WORDS - 1)) && !is_ext);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      hdr_addr <= '0;
      widx     <= '0;
      count    <= '0;
      err_r    <= 1'b0;
      for (int i = 0; i < EXT_WORDS; i++) wrd[i] <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          hdr_addr <= base_addr;
          count    <= '0;
          err_r    <= 1'b0;
          widx     <= '0;
          for (int i = 0; i < EXT_WORDS; i++) wrd[i] <= '0;
          state    <= ST_REQ;
        end
        ST_REQ: if (req_ready) state <= ST_WAIT;
        ST_WAIT: if (resp_valid) begin
          wrd[widx] <= resp_data;
          if (last_word) state <= ST_EMIT;
          else begin
            widx  <= widx + 1'b1;
            state <= ST_REQ;
          end
        end
        ST_EMIT: if (rec_ready) begin
          count <= count + 1'b1;
          if (is_last) begin
            err_r <= chain_err;
            state <= ST_DONE;
          end else begin
            hdr_addr <= hdr_addr + AW'(fld.nxt);
            widx     <= '0;
            for (int i = 0; i < EXT_WORDS; i++) wrd[i] <= '0;
            state    <= ST_REQ;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_valid    = (state == ST_REQ);
  assign req_addr     = hdr_addr + (AW'(widx) << SH);
  assign rec_valid    = (state == ST_EMIT);
  assign rec_hdr_addr = hdr_addr;
  assign rec_type     = fld.kind;
  assign rec_dfh_ver  = fld.hver;
  assign rec_rev      = fld.rev;
  assign rec_id       = fld.fid;
  assign rec_guid     = {wrd[2], wrd[1]};
  assign rec_span     = fld.nxt;
  assign rec_last     = is_last;
  assign rec_err      = chain_err;
  assign done         = (state == ST_DONE);
  assign done_count   = count;
  assign done_err     = err_r;
endmodule

// File: rtl/fw_walker_chk.sv
module fw_walker_chk #(
  parameter int AW = 64
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_addr,
  input logic          resp_valid,
  input logic          rec_valid,
  input logic          rec_ready,
  input logic [AW-1:0] rec_hdr_addr,
  input logic [127:0]  rec_guid,
  input logic [AW-1:0] rec_reg_base,
  input logic          rec_last,
  input logic          rec_err,
  input logic          done
);
  logic [1:0] outst;
  always_ff @(posedge clk) begin
    if (rst) outst <= '0;
    else if (req_valid && req_ready && !resp_valid) outst <= outst + 1'b1;
    else if (resp_valid && !(req_valid && req_ready)) outst <= outst - 1'b1;
  end

  p_req_hold_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ready |=> req_valid && $stable(req_addr));
  p_one_outstanding_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |-> outst == 2'd0);
  p_aligned_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> req_addr[2:0] == 3'd0 || $past(rst));
  p_rec_no_req_r2: assert property (@(posedge clk) disable iff (rst)
    rec_valid |-> !req_valid && outst == 2'd0);
  p_rec_hold_r9: assert property (@(posedge clk) disable iff (rst)
    rec_valid && !rec_ready |=> rec_valid && $stable(rec_hdr_addr) &&
      $stable(rec_guid) && $stable(rec_reg_base));
  p_err_is_last_r8: assert property (@(posedge clk) disable iff (rst)
    rec_valid && rec_err |-> rec_last);
  p_done_after_last_r10: assert property (@(posedge clk) disable iff (rst)
    rec_valid && rec_ready && rec_last |=> done);
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done && !rec_valid && !req_valid);
  p_reset_idle_r12: assert property (@(posedge clk)
    $past(rst) |-> !req_valid && !rec_valid && !done);
endmodule

bind feature_walker fw_walker_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .resp_valid(resp_valid), .rec_valid(rec_valid),
  .rec_ready(rec_ready), .rec_hdr_addr(rec_hdr_addr), .rec_guid(rec_guid),
  .rec_reg_base(rec_reg_base), .rec_last(rec_last), .rec_err(rec_err),
  .done(done)
);

// File: tb/test_feature_walker.sv
module test_feature_walker;
  localparam int AW = 64;
  localparam int CW = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1, start = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic req_valid, req_ready = 1'b0;
  logic [AW-1:0] req_addr;
  logic resp_valid = 1'b0;
  logic [63:0] resp_data = '0;
  logic rec_valid, rec_ready = 1'b0;
  logic [AW-1:0] rec_hdr_addr, rec_reg_base;
  logic [3:0] rec_type, rec_rev;
  logic [7:0] rec_dfh_ver;
  logic [11:0] rec_id;
  logic [127:0] rec_guid;
  logic [23:0] rec_span;
  logic [31:0] rec_reg_size;
  logic rec_has_params, rec_last, rec_err, done, done_err;
  logic [14:0] rec_group;
  logic [15:0] rec_inst;
  logic [CW-1:0] done_count;

  feature_walker #(.AW(AW), .CW(CW)) i_feature_walker (.*);

  logic [63:0] mem [1024];
  int n_chk = 0, n_bad = 0;
  logic [AW-1:0] exp_hdr = '0;
  int rec_seen = 0, reads_total = 0, reads_mark = 0;
  bit exp_err = 0, walk_done = 0;

  function automatic int idx(input logic [AW-1:0] a);
    return int'(a[12:3]);
  endfunction

  task automatic cmp(input string rq, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // memory responder: one request at a time, 0..3 cycles of latency
  initial begin
    int lat;
    bit pend;
    logic [AW-1:0] pa;
    pend = 0; lat = 0; pa = '0;
    forever begin
      @(negedge clk);
      resp_valid = 1'b0;
      if (rst) begin pend = 0; req_ready = 1'b0; end
      else if (pend) begin
        req_ready = 1'b0;
        if (lat == 0) begin resp_data = mem[idx(pa)]; resp_valid = 1'b1; pend = 0; end
        else lat--;
      end else if (req_valid && ($urandom % 3 != 0)) begin
        req_ready = 1'b1; pa = req_addr; lat = $urandom % 4; pend = 1; reads_total++;
        cmp("R2 read inside header", {127'd0, (pa - exp_hdr) < 64'h28 && pa[2:0] == 3'd0}, 128'd1);
      end else req_ready = 1'b0;
    end
  end

  task automatic check_record;
    logic [AW-1:0] a, eb;
    logic [63:0] w0, loc, sz;
    logic [23:0] nx;
    bit ext, err;
    a = exp_hdr; w0 = mem[idx(a)]; nx = w0[39:16];
    ext = (w0[59:52] == 8'd1);
    loc = ext ? mem[idx(a + 24)] : 64'd0;
    sz  = ext ? mem[idx(a + 32)] : 64'd0;
    err = !w0[40] && nx == 24'd0;
    cmp("R4 header address", rec_hdr_addr, a);
    cmp("R1 type/ver/rev/id", {rec_type, rec_dfh_ver, rec_rev, rec_id}, {w0[63:52], w0[15:0]});
    cmp("R3 guid", rec_guid, {mem[idx(a + 16)], mem[idx(a + 8)]});
    cmp("R7 span", rec_span, nx);
    if (ext) eb = loc[0] ? {loc[AW-1:1], 1'b0} : a + loc;
    else eb = a;
    cmp("R5 register base", rec_reg_base, eb);
    cmp("R6 size/params/group/inst", {rec_reg_size, rec_has_params, rec_group, rec_inst},
        ext ? sz : {8'd0, nx, 32'd0});
    cmp("R7 R8 last/err", {rec_last, rec_err}, {w0[40] || err, err});
    cmp("R2 reads per header", reads_total - reads_mark, ext ? 5 : 3);
    reads_mark = reads_total;
    rec_seen++;
    if (err) exp_err = 1;
    exp_hdr = a + AW'(nx);
  endtask

  // consumer with random back-pressure
  initial begin
    bit hold;
    logic [AW-1:0] s_addr, s_base;
    logic [127:0] s_guid;
    logic [23:0] s_span;
    hold = 0; s_addr = '0; s_base = '0; s_guid = '0; s_span = '0;
    forever begin
      @(negedge clk);
      if (rst) begin rec_ready = 1'b0; hold = 0; end
      else begin
        if (hold)
          cmp("R9 record held", {rec_valid, rec_hdr_addr, rec_reg_base, rec_span},
              {1'b1, s_addr, s_base, s_span});
        if (hold) cmp("R9 guid held", rec_guid, s_guid);
        if (done) begin
          cmp("R10 done count", done_count, CW'(rec_seen));
          cmp("R8 done error flag", done_err, exp_err);
          walk_done = 1;
        end
        if (rec_valid) begin
          rec_ready = ($urandom % 4) != 0;
          if (rec_ready) begin check_record(); hold = 0; end
          else begin
            hold = 1; s_addr = rec_hdr_addr; s_base = rec_reg_base;
            s_guid = rec_guid; s_span = rec_span;
          end
        end else begin rec_ready = 1'b0; hold = 0; end
      end
    end
  end

  task automatic put_hdr(input logic [AW-1:0] a, input logic [7:0] ver, input bit eol,
                         input logic [23:0] nx, input logic [63:0] loc, input logic [63:0] sz);
    mem[idx(a)] = {4'($urandom), ver, 11'($urandom), eol, nx, 4'($urandom), 12'($urandom)};
    mem[idx(a + 8)]  = {$urandom, $urandom};
    mem[idx(a + 16)] = {$urandom, $urandom};
    if (ver == 8'd1) begin mem[idx(a + 24)] = loc; mem[idx(a + 32)] = sz; end
  endtask

  task automatic build_chain(input logic [AW-1:0] b, input int n);
    logic [AW-1:0] a;
    a = b;
    for (int i = 0; i < n; i++) begin
      int r;
      logic [7:0] v;
      logic [63:0] loc;
      logic [23:0] nx;
      r = $urandom % 4;
      v = (r == 0) ? 8'd0 : (r == 3) ? 8'd2 : 8'd1;
      loc = ($urandom % 2) ? ({$urandom, $urandom} | 64'd1) : {48'd0, 16'($urandom) & 16'hfffe};
      nx = (i == n - 1) ? 24'($urandom) : 24'h28 + 24'(8 * ($urandom % 16));
      put_hdr(a, v, i == n - 1, nx, loc, {$urandom, $urandom});
      a = a + AW'(nx);
    end
  endtask

  task automatic launch(input logic [AW-1:0] b);
    @(negedge clk);
    exp_hdr = b; rec_seen = 0; exp_err = 0; walk_done = 0; reads_mark = reads_total;
    base_addr = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish_walk(input int n, input string rq);
    int t;
    t = 0;
    while (!walk_done && t < 5000) begin @(negedge clk); t++; end
    cmp({rq, " walk finished"}, walk_done, 1);
    cmp({rq, " record count"}, rec_seen, n);
    repeat (3) @(negedge clk);
    cmp("R10 quiet after done", {req_valid, rec_valid, done}, 3'b000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    report();
  end

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    cmp("R12 reset state", {req_valid, rec_valid, done}, 3'b000);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    cmp("R12 idle without start", {req_valid, rec_valid, done}, 3'b000);

    // single basic header, end of chain: span is the last feature's size
    put_hdr(64'h100, 8'd0, 1, 24'h1234, 64'd0, 64'd0);
    launch(64'h100); finish_walk(1, "R7");

    // extended headers: relative and absolute placement, then a basic tail
    put_hdr(64'h200, 8'd1, 0, 24'h40, 64'h80, 64'h0000_0100_8003_0007);
    put_hdr(64'h240, 8'd1, 0, 24'h60, 64'hDEAD_BEEF_0000_1001, 64'h0000_0040_0000_0002);
    put_hdr(64'h2A0, 8'd0, 1, 24'h500, 64'd0, 64'd0);
    launch(64'h200); finish_walk(3, "R5");

    // zero next offset without end flag: chain error
    put_hdr(64'h600, 8'd0, 0, 24'h0, 64'd0, 64'd0);
    launch(64'h600); finish_walk(1, "R8");
    put_hdr(64'h640, 8'd1, 0, 24'h30, 64'h41, 64'd5);
    put_hdr(64'h670, 8'd1, 0, 24'h0, 64'h10, 64'd9);
    launch(64'h640); finish_walk(2, "R8");

    // start during a walk is ignored
    build_chain(64'h700, 4);
    put_hdr(64'h1800, 8'd0, 1, 24'h10, 64'd0, 64'd0);
    launch(64'h700);
    while (rec_seen < 1) @(negedge clk);
    base_addr = 64'h1800; start = 1'b1;
    @(negedge clk); start = 1'b0;
    finish_walk(4, "R11");

    // reset in the middle of a walk
    launch(64'h200);
    while (rec_seen < 1) @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    cmp("R12 reset mid-walk", {req_valid, rec_valid, done}, 3'b000);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    cmp("R12 idle after reset", {req_valid, rec_valid, done}, 3'b000);
    launch(64'h200); finish_walk(3, "R12");

    // random chains
    for (int k = 0; k < 20; k++) begin
      int n;
      logic [AW-1:0] b;
      n = 1 + $urandom % 8;
      b = AW'(8 * ($urandom % 128));
      build_chain(b, n);
      launch(b); finish_walk(n, "R4");
    end
    report();
  end
endmodule